// File: doc/BRIEF.md
# Power-Management Control and Status Register

This block is the 16-bit power-management control and status word of a PCI-style function. Configuration software reads it and writes it through a byte-enabled config port. The word holds four kinds of field: a write-one-to-clear event status bit, a read/write event enable bit, a two-bit power-state field, and constant fields. When the status bit and the enable bit are both set, the block raises an internal power-management event.

The block also sits in front of the function's memory-space port. While the power state is D3hot, it refuses every memory request and answers it with an error flag. Configuration accesses are served in every power state.

The block has two resets. The suspend-well reset covers only the status and enable bits, so those two bits survive a core reset. The core reset returns every other field to its default.

Top module: `pm_csr`

## Requirements
- R1: Bit 15 is the event status bit and resets to 0. A config write with a 1 in bit 15 clears it. A 0 in bit 15 leaves it unchanged.
- R2: A cycle with `wake_cond` high sets the status bit in the next cycle, whether or not the enable bit is set.
- R3: Bit 8 is the event enable bit. It is read/write and resets to 0. `pme_o` is high exactly while both the status bit and the enable bit are 1.
- R4: Bits 14:9, 7:4 and 2 always read 0 and bit 3 always reads 1, whatever value was written to them.
- R5: Bits 1:0 hold the power state, with 00 meaning D0 and 11 meaning D3hot. They reset to 00. A write of 00 or 11 takes effect in the next cycle.
- R6: A write of 01 or 10 to bits 1:0 is accepted, but it is discarded and the power state keeps its value.
- R7: In D3hot a memory request is not passed on. `fn_req` stays low, `mem_err` is high and `mem_rdata` is zero. In D0 the request, its write flag and its read data pass straight through with `mem_err` low.
- R8: A core reset returns the power state to 00 and keeps the status and enable bits. A suspend reset clears the status and enable bits.
- R9: `cfg_wr_be[1]` gates bits 15:8 and `cfg_wr_be[0]` gates bits 7:0. A field in a byte whose enable is low keeps its value, and this includes the clear of the status bit.
- R10: When a wake condition and a write-one-to-clear of bit 15 arrive in the same cycle, the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst_n | input | 1 | Core reset, asynchronous, active low |
| sus_rst_n | input | 1 | Suspend-well reset, asynchronous, active low |
| cfg_wr_en | input | 1 | Config write strobe |
| cfg_wr_be | input | 2 | Config write byte enables |
| cfg_wr_data | input | 16 | Config write data |
| cfg_rd_data | output | 16 | Current register value |
| wake_cond | input | 1 | Wake condition from the function |
| pme_o | output | 1 | Internal power-management event |
| pwr_state | output | 2 | Current power state |
| mem_req | input | 1 | Memory request from the host side |
| mem_we | input | 1 | Memory request is a write |
| mem_addr | input | MEM_AW | Memory address |
| mem_wdata | input | MEM_DW | Memory write data |
| mem_rdata | output | MEM_DW | Memory read data returned to the host side |
| mem_err | output | 1 | Request refused because the function is in D3hot |
| fn_req | output | 1 | Request passed on to the function |
| fn_we | output | 1 | Write flag passed on to the function |
| fn_addr | output | MEM_AW | Address passed on to the function |
| fn_wdata | output | MEM_DW | Write data passed on to the function |
| fn_rdata | input | MEM_DW | Read data from the function |

## Verification
The bench builds the block with MEM_DW = 16 and MEM_AW = 8. At this width a single comparison covers every bit of the read data that must be forced to zero in D3hot. The config register itself has a fixed 16-bit layout and does not depend on either parameter, so the byte-enable masking, the race between wake and clear, and the behaviour of the two reset domains are all exercised in full.

// File: rtl/pm_csr.sv
module pm_csr #(
  parameter int MEM_DW = 32,
  parameter int MEM_AW = 12
) (
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              sus_rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_be,
  input  logic [15:0]       cfg_wr_data,
  output logic [15:0]       cfg_rd_data,
  input  logic              wake_cond,
  output logic              pme_o,
  output logic [1:0]        pwr_state,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [MEM_DW-1:0] mem_wdata,
  output logic [MEM_DW-1:0] mem_rdata,
  output logic              mem_err,
  output logic              fn_req,
  output logic              fn_we,
  output logic [MEM_AW-1:0] fn_addr,
  output logic [MEM_DW-1:0] fn_wdata,
  input  logic [MEM_DW-1:0] fn_rdata
);
  localparam logic [1:0] PS_D0 = 2'b00;
  localparam logic [1:0] PS_D3 = 2'b11;

  logic       evt_sts, evt_en;
  logic [1:0] ps;

  wire wr_hi  = cfg_wr_en & cfg_wr_be[1];
  wire wr_lo  = cfg_wr_en & cfg_wr_be[0];
  wire ps_ok  = (cfg_wr_data[1:0] == PS_D0) | (cfg_wr_data[1:0] == PS_D3);
  wire in_d3  = (ps == PS_D3);

  always_ff @(posedge clk or negedge sus_rst_n)
    if (!sus_rst_n) begin
      evt_sts <= 1'b0;
      evt_en  <= 1'b0;
    end else begin
      if (wake_cond)                       evt_sts <= 1'b1;
      else if (wr_hi && cfg_wr_data[15])   evt_sts <= 1'b0;
      if (wr_hi)                           evt_en  <= cfg_wr_data[8];
    end

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n)          ps <= PS_D0;
    else if (wr_lo && ps_ok)  ps <= cfg_wr_data[1:0];

  assign cfg_rd_data = {evt_sts, 6'b0, evt_en, 4'b0, 1'b1, 1'b0, ps};
  assign pme_o       = evt_sts & evt_en;
  assign pwr_state   = ps;

  assign fn_req    = mem_req & ~in_d3;
  assign fn_we     = mem_we & ~in_d3;
  assign fn_addr   = mem_addr;
  assign fn_wdata  = mem_wdata;
  assign mem_err   = mem_req & in_d3;
  assign mem_rdata = in_d3 ? '0 : fn_rdata;

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!core_rst_n || !sus_rst_n)
    wake_cond |=> cfg_rd_data[15]); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!core_rst_n || !sus_rst_n)
    (cfg_wr_en && cfg_wr_be[1] && cfg_wr_data[15] && !wake_cond) |=> !cfg_rd_data[15]); // R1

  AST_BAD_PS_KEPT: assert property (@(posedge clk) disable iff (!core_rst_n || !sus_rst_n)
    (cfg_wr_en && cfg_wr_be[0] && (cfg_wr_data[1] ^ cfg_wr_data[0])) |=> $stable(pwr_state)); // R6

  AST_D3_BLOCK: assert property (@(posedge clk) disable iff (!core_rst_n || !sus_rst_n)
    (mem_req && pwr_state == 2'b11) |-> (mem_err && !fn_req && mem_rdata == '0)); // R7

  AST_PME_NEEDS_EN: assert property (@(posedge clk) disable iff (!core_rst_n || !sus_rst_n)
    (cfg_wr_en && cfg_wr_be[1] && !cfg_wr_data[8]) |=> !pme_o); // R3

  AST_HI_BYTE_GATE: assert property (@(posedge clk) disable iff (!core_rst_n || !sus_rst_n)
    (cfg_wr_en && !cfg_wr_be[1] && !wake_cond) |=> (cfg_rd_data[15:8] == $past(cfg_rd_data[15:8]))); // R9
endmodule

// File: tb/tb_pm_csr.sv
module tb_pm_csr;
  localparam int DW = 16;
  localparam int AW = 8;

  logic clk = 0;
  logic core_rst_n = 0, sus_rst_n = 0;
  logic cfg_wr_en = 0;
  logic [1:0] cfg_wr_be = 0;
  logic [15:0] cfg_wr_data = 0;
  logic [15:0] cfg_rd_data;
  logic wake_cond = 0;
  logic pme_o;
  logic [1:0] pwr_state;
  logic mem_req = 0, mem_we = 0;
  logic [AW-1:0] mem_addr = 0;
  logic [DW-1:0] mem_wdata = 0, mem_rdata, fn_rdata = 16'hA5C3;
  logic mem_err, fn_req, fn_we;
  logic [AW-1:0] fn_addr;
  logic [DW-1:0] fn_wdata;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pm_csr #(.MEM_DW(DW), .MEM_AW(AW)) dut (
    .clk, .core_rst_n, .sus_rst_n, .cfg_wr_en, .cfg_wr_be, .cfg_wr_data, .cfg_rd_data,
    .wake_cond, .pme_o, .pwr_state, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata, .mem_err, .fn_req, .fn_we, .fn_addr, .fn_wdata, .fn_rdata);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [15:0] d, logic [1:0] be, logic wk = 1'b0);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_data = d; cfg_wr_be = be; wake_cond = wk;
    @(negedge clk);
    cfg_wr_en = 0; wake_cond = 0;
    #1;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_cond = 1;
    @(negedge clk); wake_cond = 0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 R3 R5 reset value", cfg_rd_data, 16'h0008);
    chk("R3 reset pme", pme_o, 0);
  endtask

  task automatic t_const_fields();
    cfg_wr(16'hFFFF, 2'b11);
    chk("R4 constant fields after all-ones write", cfg_rd_data, 16'h010B);
    cfg_wr(16'h0000, 2'b11);
    chk("R4 R5 constant fields after zero write", cfg_rd_data, 16'h0008);
  endtask

  task automatic t_event();
    pulse_wake();
    chk("R2 wake sets status with enable off", cfg_rd_data[15], 1);
    chk("R3 no pme without enable", pme_o, 0);
    cfg_wr(16'h0000, 2'b10);
    chk("R1 writing 0 keeps status", cfg_rd_data[15], 1);
    cfg_wr(16'h0100, 2'b10);
    chk("R3 pme with status and enable", pme_o, 1);
    cfg_wr(16'h8000, 2'b01);
    chk("R9 clear ignored in disabled byte", cfg_rd_data[15], 1);
    cfg_wr(16'h8100, 2'b10);
    chk("R1 write 1 clears status", cfg_rd_data, 16'h0108);
    chk("R3 pme drops after clear", pme_o, 0);
  endtask

  task automatic t_race();
    cfg_wr(16'h8100, 2'b10, 1'b1);
    chk("R10 wake beats clear", cfg_rd_data[15], 1);
    chk("R10 pme stays", pme_o, 1);
    cfg_wr(16'h8000, 2'b10);
    chk("R1 R3 clear status and enable", cfg_rd_data, 16'h0008);
  endtask

  task automatic t_power();
    cfg_wr(16'h0003, 2'b01);
    chk("R5 enter D3hot", pwr_state, 2'b11);
    cfg_wr(16'h0001, 2'b01);
    chk("R6 write 01 discarded", pwr_state, 2'b11);
    cfg_wr(16'h0002, 2'b01);
    chk("R6 write 10 discarded", pwr_state, 2'b11);
    @(negedge clk); mem_req = 1; mem_we = 1; mem_addr = 8'h3C; #1;
    chk("R7 D3 err", mem_err, 1);
    chk("R7 D3 no fn_req", fn_req, 0);
    chk("R7 D3 rdata zero", mem_rdata, 16'h0000);
    chk("R7 config still readable", cfg_rd_data, 16'h000B);
    @(negedge clk); mem_req = 0; mem_we = 0;
    cfg_wr(16'h0000, 2'b10);
    chk("R9 low byte disabled keeps state", pwr_state, 2'b11);
    cfg_wr(16'h0000, 2'b01);
    chk("R5 back to D0", pwr_state, 2'b00);
    @(negedge clk); mem_req = 1; mem_we = 1; #1;
    chk("R7 D0 passes req", fn_req, 1);
    chk("R7 D0 passes we", fn_we, 1);
    chk("R7 D0 addr", fn_addr, 8'h3C);
    chk("R7 D0 no err", mem_err, 0);
    chk("R7 D0 rdata", mem_rdata, 16'hA5C3);
    @(negedge clk); mem_req = 0; mem_we = 0;
  endtask

  task automatic t_resets();
    cfg_wr(16'h0103, 2'b11);
    pulse_wake();
    chk("R8 setup", cfg_rd_data, 16'h810B);
    @(negedge clk); core_rst_n = 0;
    @(negedge clk); core_rst_n = 1; #1;
    chk("R8 core reset keeps event bits, clears state", cfg_rd_data, 16'h8108);
    chk("R8 pme survives core reset", pme_o, 1);
    @(negedge clk); sus_rst_n = 0;
    @(negedge clk); sus_rst_n = 1; #1;
    chk("R8 suspend reset clears event bits", cfg_rd_data, 16'h0008);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    core_rst_n = 1; sus_rst_n = 1;
    #1;
    t_reset();
    t_const_fields();
    t_event();
    t_race();
    t_power();
    t_resets();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule